// File: doc/BRIEF.md
# Sign-Magnitude Integer Adder

This block adds two signed integers held in sign-magnitude form and returns their sum in the same form, together with an overflow flag. It is purely combinational: a result appears on the outputs in the same cycle that the operands are presented, so a surrounding pipeline can register it wherever its timing needs.

Each operand packs a sign bit above an unsigned magnitude. A small control section looks at the two signs and compares the two magnitudes. From these it decides whether the magnitudes should be added or the smaller taken from the larger. It also decides which operand is the larger and what sign the result carries. A datapath section then runs one shared ripple adder, inverting its second input for a subtraction. It raises overflow when a same-sign sum does not fit, and it forces every zero result to the positive encoding. Both zero encodings are accepted on the inputs.

Top module: `sm_adder`

## Requirements
- R1: Operands and result use `WIDTH` bits (default 4): bit `WIDTH-1` is the sign (1 = negative, 0 = positive) and bits `WIDTH-2:0` are an unsigned magnitude, so the values span -(2^(WIDTH-1)-1) to +(2^(WIDTH-1)-1), i.e. -7 to +7 at the default.
- R2: When both operand signs match and the magnitude sum fits, the result magnitude is the sum of the magnitudes and the result sign is the shared sign (unless the result is zero, see R6).
- R3: The overflow flag is 1 exactly when the signs match and the magnitude sum exceeds 2^(WIDTH-1)-1 (for 4 bits, 5+7 and -5+-7 both flag); operands with differing signs never raise it. While the flag is 1 the sum output carries no defined value.
- R4: When the signs differ, the result magnitude is the larger magnitude minus the smaller, and the result sign is that of the operand with the larger magnitude.
- R5: When the signs differ and the magnitudes are equal, the result is positive zero (all bits 0).
- R6: Any result whose magnitude is zero has sign 0; the negative-zero pattern (only the sign bit set) never appears on the output while overflow is 0.
- R7: An operand equal to negative zero behaves exactly like positive zero: adding it to any operand X yields X's value (with zero normalised as in R6) and never raises overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand, sign-magnitude |
| opB | input | WIDTH | Second operand, sign-magnitude |
| sumOut | output | WIDTH | Sum, sign-magnitude; undefined while overflow is 1 |
| overflow | output | 1 | Same-sign magnitude sum out of range |

## Verification
The assertions watch, for every operand pair that appears, that differing signs never raise overflow, that no negative zero leaves the block, that a subtraction never yields a magnitude above the larger input, and that a non-zero same-sign result keeps the shared sign. Whether a magnitude is numerically right, and whether the larger operand's sign wins a mixed-sign sum, can only be shown by the bench. It compares every result with an integer model across directed corner cases (range edges, equal magnitudes, both zero encodings) and a sweep of all operand pairs at the default width.

// File: rtl/sm_adder_pkg.sv
package sm_adder_pkg;

  // Strobes from the sign/compare control to the magnitude datapath.
  typedef struct packed {
    logic doSub;       // signs differ: larger minus smaller
    logic swapOps;     // B magnitude is strictly larger than A
    logic resultSign;  // sign to attach before zero normalisation
  } smAddCtrl_t;

endpackage

// File: rtl/sm_adder_ctrl.sv
module sm_adder_ctrl
  import sm_adder_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int MAG_W = WIDTH - 1
) (
  input  logic             signA,
  input  logic             signB,
  input  logic [MAG_W-1:0] magA,
  input  logic [MAG_W-1:0] magB,
  output smAddCtrl_t       ctrl
);

  logic [MAG_W:0] gtChain;  // B > A decided at or above bit i
  logic [MAG_W:0] eqChain;  // equal at or above bit i
  logic           bLarger;

  // MSB-first magnitude compare; a zero magnitude compares the same
  // whatever its sign bit says.
  assign gtChain[MAG_W] = 1'b0;
  assign eqChain[MAG_W] = 1'b1;

  for (genvar i = MAG_W - 1; i >= 0; i--) begin : g_cmp
    assign gtChain[i] = gtChain[i+1] | (eqChain[i+1] & magB[i] & ~magA[i]);
    assign eqChain[i] = eqChain[i+1] & (magA[i] ~^ magB[i]);
  end

  assign bLarger = gtChain[0];

  always_comb begin
    ctrl.doSub      = signA ^ signB;
    ctrl.swapOps    = bLarger;
    if (signA == signB) begin
      ctrl.resultSign = signA;
    end else begin
      ctrl.resultSign = bLarger ? signB : signA;
    end
  end

  // R4: a swap is only ever requested when B really is larger
  always_comb begin
    p_swap_larger_r4: assert (!ctrl.swapOps || (magB > magA))
      else $error("swap requested with B not larger");
  end

endmodule

// File: rtl/sm_adder_datapath.sv
module sm_adder_datapath
  import sm_adder_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int MAG_W = WIDTH - 1
) (
  input  logic [MAG_W-1:0] magA,
  input  logic [MAG_W-1:0] magB,
  input  smAddCtrl_t       ctrl,
  output logic [MAG_W-1:0] magSum,
  output logic             signOut,
  output logic             overflow
);

  logic [MAG_W-1:0] bigMag;
  logic [MAG_W-1:0] smallMag;
  logic [MAG_W-1:0] addend;
  logic [MAG_W:0]   carry;
  logic             isZero;

  assign bigMag   = ctrl.swapOps ? magB : magA;
  assign smallMag = ctrl.swapOps ? magA : magB;
  assign addend   = ctrl.doSub ? ~smallMag : smallMag;
  assign carry[0] = ctrl.doSub;

  // Shared ripple chain for both add and subtract.
  for (genvar i = 0; i < MAG_W; i++) begin : g_fa
    assign magSum[i]  = bigMag[i] ^ addend[i] ^ carry[i];
    assign carry[i+1] = (bigMag[i] & addend[i]) |
                        (carry[i] & (bigMag[i] ^ addend[i]));
  end

  assign isZero   = (magSum == '0);
  assign overflow = ~ctrl.doSub & carry[MAG_W];
  assign signOut  = ctrl.resultSign & ~isZero;

  // R4: subtraction never produces more than the larger magnitude
  always_comb begin
    p_sub_bounded_r4: assert (!ctrl.doSub || (magSum <= bigMag))
      else $error("difference exceeds larger magnitude");
  end

endmodule

// File: rtl/sm_adder.sv
module sm_adder
  import sm_adder_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut,
  output logic             overflow
);

  localparam int MAG_W = WIDTH - 1;

  smAddCtrl_t       ctrl;
  logic [MAG_W-1:0] magSum;
  logic             signOut;

  sm_adder_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .signA (opA[WIDTH-1]),
    .signB (opB[WIDTH-1]),
    .magA  (opA[MAG_W-1:0]),
    .magB  (opB[MAG_W-1:0]),
    .ctrl  (ctrl)
  );

  sm_adder_datapath #(.WIDTH(WIDTH)) u_dp (
    .magA     (opA[MAG_W-1:0]),
    .magB     (opB[MAG_W-1:0]),
    .ctrl     (ctrl),
    .magSum   (magSum),
    .signOut  (signOut),
    .overflow (overflow)
  );

  assign sumOut = {signOut, magSum};

  always_comb begin
    // R3: mixed signs can never overflow
    p_no_overflow_r3: assert (!((opA[WIDTH-1] != opB[WIDTH-1]) && overflow))
      else $error("overflow with differing signs");
    // R6: no negative zero on the output
    p_no_neg_zero_r6: assert (overflow || (sumOut != {1'b1, {MAG_W{1'b0}}}))
      else $error("negative zero produced");
    // R2: a non-zero same-sign sum keeps the shared sign
    p_same_sign_r2: assert (overflow || (opA[WIDTH-1] != opB[WIDTH-1]) ||
                            (sumOut[MAG_W-1:0] == '0) ||
                            (sumOut[WIDTH-1] == opA[WIDTH-1]))
      else $error("same-sign result lost its sign");
  end

endmodule

// File: tb/sm_adder_bench.sv
module sm_adder_bench;

  localparam int W    = 4;
  localparam int MAXV = (1 << (W - 1)) - 1;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] expSum;
    logic         expOvf;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] sumOut;
  logic         overflow;

  int    nTests = 0;
  int    nFail  = 0;
  bit    drvDone = 1'b0;
  item_t sbq[$];

  always #2 clk = ~clk;

  sm_adder #(.WIDTH(W)) u_sm_adder (
    .opA      (opA),
    .opB      (opB),
    .sumOut   (sumOut),
    .overflow (overflow)
  );

  function automatic int toInt(input logic [W-1:0] v);
    int m;
    m = int'(v[W-2:0]);
    return v[W-1] ? -m : m;
  endfunction

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    item_t it;
    int    s;
    int    m;
    @(posedge clk);
    #1;
    opA = a;
    opB = b;
    s = toInt(a) + toInt(b);
    m = (s < 0) ? -s : s;
    it.a = a;
    it.b = b;
    it.tag = tag;
    it.expOvf = (m > MAXV);
    it.expSum = {(s < 0), m[W-2:0]};
    sbq.push_back(it);
  endtask

  // Monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        nTests++;
        if (it.expOvf) begin
          if (overflow !== 1'b1) begin
            nFail++;
            $display("FAIL %s: a=%b b=%b got ovf=%b expected ovf=1",
                     it.tag, it.a, it.b, overflow);
          end
        end else if (overflow !== 1'b0 || sumOut !== it.expSum) begin
          nFail++;
          $display("FAIL %s: a=%b b=%b got sum=%b ovf=%b expected sum=%b ovf=0",
                   it.tag, it.a, it.b, sumOut, overflow, it.expSum);
        end
      end
    end
  end

  // Driver
  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    send(4'b0000, 4'b0000, "R1 reset idle zero");
    send(4'b0010, 4'b0011, "R2 +2 + +3");
    send(4'b1010, 4'b1011, "R2 -2 + -3");
    send(4'b0011, 4'b0100, "R1 R2 +3 + +4 top of range");
    send(4'b1011, 4'b1100, "R2 -3 + -4 bottom of range");
    send(4'b0101, 4'b0111, "R3 +5 + +7");
    send(4'b1101, 4'b1111, "R3 -5 + -7");
    send(4'b0100, 4'b0100, "R3 +4 + +4 just over");
    send(4'b0111, 4'b1111, "R3 R5 +7 + -7 no overflow");
    send(4'b0101, 4'b1111, "R4 +5 + -7");
    send(4'b1101, 4'b0111, "R4 -5 + +7");
    send(4'b0110, 4'b1001, "R4 +6 + -1");
    send(4'b1110, 4'b0001, "R4 -6 + +1");
    send(4'b0011, 4'b1011, "R5 +3 + -3");
    send(4'b1011, 4'b0011, "R5 -3 + +3");
    send(4'b1000, 4'b1000, "R6 R7 -0 + -0");
    send(4'b1000, 4'b0000, "R6 R7 -0 + +0");
    send(4'b1000, 4'b0101, "R7 -0 + +5");
    send(4'b1101, 4'b1000, "R7 -5 + -0");
    send(4'b0111, 4'b1000, "R7 +7 + -0");
    send(4'b1000, 4'b1111, "R7 -0 + -7");
    for (int i = 0; i < (1 << W); i++) begin
      for (int j = 0; j < (1 << W); j++) begin
        send(W'(i), W'(j), "R1 R2 R3 R4 R6 sweep");
      end
    end
    drvDone = 1'b1;
  end

  // End of run
  initial begin
    wait (drvDone);
    wait (sbq.size() == 0);
    @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  // Watchdog
  initial begin
    #200000;
    nTests++;
    nFail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule